// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of a data-processing ALU. It takes a 32-bit base value and shifts or rotates it. It also produces the carry-out that a flag-setting instruction would take from the shifter.

**Shift amount source.** The amount comes from one of two places, chosen by a mode input:

- **Immediate mode.** The amount is a 5-bit field of the instruction. A zero amount is reinterpreted according to the shift kind.
- **Register mode.** The amount is an 8-bit value read from a register. It can reach 32 or more, and those large amounts saturate with their own carry rules.

**Timing.** The operand and carry are computed combinationally and captured in output registers. A result therefore appears one clock after its inputs are presented. Nothing stalls or throttles the flow: a new set of inputs may be presented every cycle.

**Shift kind encoding** (`kind_i`):

| Code | Kind |
|------|------|
| 00 | logical left |
| 01 | logical right |
| 10 | arithmetic right |
| 11 | rotate right |

`by_reg_i` selects the mode: 0 for immediate, 1 for register.

Top module: `sop_unit`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become 0. Otherwise the outputs registered at a clock edge are the function of the inputs present at that edge, so the latency is one cycle.
- R2: In immediate mode, logical left with amount 0 returns the base unchanged, and the carry-out equals `carry_i`.
- R3: In immediate mode, logical right with amount 0 acts as a shift by 32. The result is 0 and the carry-out is base bit 31.
- R4: In immediate mode, arithmetic right with amount 0 acts as a shift by 32. Every result bit and the carry-out equal base bit 31.
- R5: In immediate mode, rotate right with amount 0 is a 33-bit rotate through carry. The result is {`carry_i`, base[31:1]} and the carry-out is base[0].
- R6: For an effective amount n from 1 to 31, in either mode, the result is the base shifted or rotated by n. The carry-out is the last bit moved out: base[32-n] for logical left, and base[n-1] for the other three kinds.
- R7: In register mode with amount 0, every kind returns the base unchanged, and the carry-out equals `carry_i`.
- R8: In register mode, logical left or logical right by 32 or more gives 0. At exactly 32 the carry-out is base[0] for left and base[31] for right. Above 32 the carry-out is 0.
- R9: In register mode, arithmetic right by 32 or more fills the result with base[31], and the carry-out is base[31].
- R10: In register mode, rotate right uses only amount bits [4:0]. When those bits are 0 and the amount is nonzero, the result is the base unchanged and the carry-out is base[31].
- R11: In immediate mode, amount bits [7:5] are ignored. Any amount gives the same outputs as its low five bits alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | W (32) | Value to be shifted |
| kind_i | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| by_reg_i | input | 1 | 0 selects immediate mode, 1 selects register mode |
| amount_i | input | AW (8) | Shift amount; immediate mode uses bits [4:0] only |
| carry_i | input | 1 | Current carry flag |
| result_o | output | W (32) | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry-out |

## Verification
The assertions assume that every input is defined and held stable across each rising edge. They also assume that inputs sampled in the cycle before a check belong to the same operation, with no reset in between.

The scoreboard driver changes inputs only on falling edges and presents one complete operation per cycle. This keeps each registered output paired with exactly one set of inputs. The sweep covers every kind, both modes and all 256 amounts. Random base values are used so that the sign bit and the low bit take both values.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/sop_imm_path.sv
// Immediate-amount path: zero amount is reinterpreted per kind.
module sop_imm_path
  import sop_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  base,
  input  shift_kind_e   kind,
  input  logic [SW-1:0] n,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  always_comb begin
    int k;
    k = int'(n);
    res  = base;
    cout = cin;
    if (k == 0) begin
      unique case (kind)
        SK_LSL: begin res = base;                 cout = cin;         end
        SK_LSR: begin res = '0;                   cout = base[W-1];   end
        SK_ASR: begin res = {W{base[W-1]}};       cout = base[W-1];   end
        default: begin res = {cin, base[W-1:1]};  cout = base[0];     end
      endcase
    end else begin
      unique case (kind)
        SK_LSL: begin res = base << k;                 cout = base[W-k]; end
        SK_LSR: begin res = base >> k;                 cout = base[k-1]; end
        SK_ASR: begin res = $signed(base) >>> k;       cout = base[k-1]; end
        default: begin res = (base >> k) | (base << (W-k)); cout = base[k-1]; end
      endcase
    end
  end
endmodule

// File: rtl/sop_reg_path.sv
// Register-amount path: large amounts saturate, rotate folds to low bits.
module sop_reg_path
  import sop_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  base,
  input  shift_kind_e   kind,
  input  logic [AW-1:0] a,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout
);
  always_comb begin
    int k;
    int r;
    k = int'(a);
    r = int'(a[SW-1:0]);
    res  = base;
    cout = cin;
    if (k != 0) begin
      unique case (kind)
        SK_LSL: begin
          if (k < W)       begin res = base << k; cout = base[W-k]; end
          else if (k == W) begin res = '0;        cout = base[0];   end
          else             begin res = '0;        cout = 1'b0;      end
        end
        SK_LSR: begin
          if (k < W)       begin res = base >> k; cout = base[k-1]; end
          else if (k == W) begin res = '0;        cout = base[W-1]; end
          else             begin res = '0;        cout = 1'b0;      end
        end
        SK_ASR: begin
          if (k < W) begin res = $signed(base) >>> k; cout = base[k-1]; end
          else       begin res = {W{base[W-1]}};      cout = base[W-1]; end
        end
        default: begin
          if (r == 0) begin res = base; cout = base[W-1]; end
          else begin
            res  = (base >> r) | (base << (W-r));
            cout = base[r-1];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sop_unit.sv
// Top: selects the amount path by mode and registers the operand.
module sop_unit
  import sop_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  base_i,
  input  logic [1:0]    kind_i,
  input  logic          by_reg_i,
  input  logic [AW-1:0] amount_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  localparam int SW = $clog2(W);

  shift_kind_e kind;
  logic [W-1:0] imm_res, reg_res;
  logic         imm_c, reg_c;

  assign kind = shift_kind_e'(kind_i);

  sop_imm_path #(.W(W), .SW(SW)) imm_i (
    .base(base_i), .kind(kind), .n(amount_i[SW-1:0]), .cin(carry_i),
    .res(imm_res), .cout(imm_c)
  );

  sop_reg_path #(.W(W), .AW(AW), .SW(SW)) reg_i (
    .base(base_i), .kind(kind), .a(amount_i), .cin(carry_i),
    .res(reg_res), .cout(reg_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      carry_o  <= 1'b0;
    end else begin
      result_o <= by_reg_i ? reg_res : imm_res;
      carry_o  <= by_reg_i ? reg_c   : imm_c;
    end
  end
endmodule

// File: rtl/sop_unit_chk.sv
module sop_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  base_i,
  input logic [1:0]    kind_i,
  input logic          by_reg_i,
  input logic [AW-1:0] amount_i,
  input logic          carry_i,
  input logic [W-1:0]  result_o,
  input logic          carry_o
);
  localparam int SW = $clog2(W);

  assert_lsr_imm_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!by_reg_i && kind_i == 2'b01 && amount_i[SW-1:0] == '0)
      |=> (result_o == '0 && carry_o == $past(base_i[W-1])));

  assert_rrx_R5: assert property (@(posedge clk) disable iff (rst)
    (!by_reg_i && kind_i == 2'b11 && amount_i[SW-1:0] == '0)
      |=> (result_o[W-1] == $past(carry_i) && carry_o == $past(base_i[0])));

  assert_reg_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (by_reg_i && amount_i == '0)
      |=> (result_o == $past(base_i) && carry_o == $past(carry_i)));

  assert_logical_big_R8: assert property (@(posedge clk) disable iff (rst)
    (by_reg_i && !kind_i[1] && int'(amount_i) > W)
      |=> (result_o == '0 && !carry_o));

  assert_asr_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (by_reg_i && kind_i == 2'b10 && int'(amount_i) >= W)
      |=> ((result_o == '0 || result_o == '1) && carry_o == result_o[W-1]));
endmodule

bind sop_unit sop_unit_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .base_i(base_i), .kind_i(kind_i),
  .by_reg_i(by_reg_i), .amount_i(amount_i), .carry_i(carry_i),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/sop_unit_tb_top.sv
`timescale 1ns/1ps
module sop_unit_tb_top;
  localparam int W  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  base_i = '0;
  logic [1:0]    kind_i = '0;
  logic          by_reg_i = 1'b0;
  logic [AW-1:0] amount_i = '0;
  logic          carry_i = 1'b0;
  logic [W-1:0]  result_o;
  logic          carry_o;

  always #5 clk = ~clk;

  sop_unit #(.W(W), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .base_i(base_i), .kind_i(kind_i),
    .by_reg_i(by_reg_i), .amount_i(amount_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         c;
    string        tag;
  } item_t;

  item_t sb_q[$];
  int total = 0;
  int bad   = 0;
  logic live = 1'b0;
  logic live_q = 1'b0;
  bit done = 1'b0;

  // Reference: step one bit position at a time, tracking the bit moved out.
  function automatic item_t model(logic [W-1:0] b, logic [1:0] k, logic m,
                                  logic [AW-1:0] a, logic ci);
    item_t it;
    logic [W-1:0] r;
    logic c;
    int s;
    r = b; c = ci; s = 0;
    it.tag = "R6";
    if (!m) begin
      s = int'(a[4:0]);
      if (a >= 32) it.tag = "R11";
      if (s == 0) begin
        case (k)
          2'b00: begin s = 0;  if (a < 32) it.tag = "R2"; end
          2'b01: begin s = W;  if (a < 32) it.tag = "R3"; end
          2'b10: begin s = W;  if (a < 32) it.tag = "R4"; end
          default: begin
            if (a < 32) it.tag = "R5";
            it.res = {ci, b[W-1:1]}; it.c = b[0];
            return it;
          end
        endcase
      end
    end else begin
      if (a == 0) begin
        it.tag = "R7"; it.res = b; it.c = ci;
        return it;
      end
      if (k == 2'b11) begin
        s = int'(a[4:0]);
        if (s == 0) begin
          it.tag = "R10"; it.res = b; it.c = b[W-1];
          return it;
        end
      end else begin
        s = int'(a);
        if (s >= W) it.tag = (k == 2'b10) ? "R9" : "R8";
      end
    end
    for (int i = 0; i < s; i++) begin
      case (k)
        2'b00: begin c = r[W-1]; r = {r[W-2:0], 1'b0}; end
        2'b01: begin c = r[0];   r = {1'b0, r[W-1:1]}; end
        2'b10: begin c = r[0];   r = {r[W-1], r[W-1:1]}; end
        default: begin c = r[0]; r = {r[0], r[W-1:1]}; end
      endcase
    end
    it.res = r; it.c = c;
    return it;
  endfunction

  task automatic drive(logic [W-1:0] b, logic [1:0] k, logic m,
                       logic [AW-1:0] a, logic ci);
    @(negedge clk);
    base_i = b; kind_i = k; by_reg_i = m; amount_i = a; carry_i = ci;
    live = 1'b1;
    sb_q.push_back(model(b, k, m, a, ci));
  endtask

  always @(posedge clk) live_q <= live;

  // Monitor: compare one registered result per live cycle.
  always @(negedge clk) begin
    if (live_q && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      total++;
      if (result_o !== e.res || carry_o !== e.c) begin
        bad++;
        $display("FAIL %s: got res=%h c=%b expected res=%h c=%b (kind=%b reg=%b amt=%0d)",
                 e.tag, result_o, carry_o, e.res, e.c, kind_i, by_reg_i, amount_i);
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (result_o !== '0 || carry_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: got res=%h c=%b expected res=0 c=0", result_o, carry_o);
    end
    rst = 1'b0;

    // Directed corners
    drive(32'h8000_0001, 2'b00, 1'b0, 8'd0,   1'b1);  // R2
    drive(32'h8000_0001, 2'b01, 1'b0, 8'd0,   1'b0);  // R3
    drive(32'h8000_0000, 2'b10, 1'b0, 8'd0,   1'b0);  // R4
    drive(32'h0000_0003, 2'b11, 1'b0, 8'd0,   1'b1);  // R5
    drive(32'h0000_0001, 2'b00, 1'b1, 8'd32,  1'b0);  // R8 exact
    drive(32'h8000_0000, 2'b01, 1'b1, 8'd32,  1'b0);  // R8 exact
    drive(32'hFFFF_FFFF, 2'b00, 1'b1, 8'd33,  1'b1);  // R8 above
    drive(32'h8000_0000, 2'b10, 1'b1, 8'd200, 1'b0);  // R9
    drive(32'h8000_0000, 2'b11, 1'b1, 8'd64,  1'b0);  // R10
    drive(32'h1234_5678, 2'b01, 1'b1, 8'd0,   1'b1);  // R7
    drive(32'h8000_0001, 2'b00, 1'b0, 8'd32,  1'b1);  // R11
    drive(32'hA5A5_A5A5, 2'b11, 1'b0, 8'd7,   1'b0);  // R6

    // R1: one-cycle latency during back-to-back operations, full sweep
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < 256; a++)
          drive($urandom, k[1:0], m[0], a[7:0], $urandom_range(0, 1));

    @(negedge clk);
    live = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule